// File: doc/BRIEF.md
# Coded-Row Freshness Tracker with Age-Ordered Recode Queue

This block sits beside a set of single-port data banks that are shadowed by XOR parity banks. Parity bank `p` combines data bank `p` with data bank `p+1`. For every row of every data bank, the block keeps a two-bit freshness code. The code says whether data and parity agree, whether the data copy is the newer one, or whether a parity copy holds the newest value. A read scheduler looks the code up combinationally by bank and row, so it can steer a read in the same cycle toward a copy that is current.

Each accepted write updates the code of its row and queues a recode job. The job holds the bank, the row, the direction of the repair, a mask of the banks that are now stale, and the free-running cycle count at the time of the write. A recode engine always sees the oldest pending job at the output. When the engine reports the job done, the row returns to clean and the job is removed. A second write to a row that already has a pending job rewrites that job instead of adding a new one. When every queue slot is occupied, a full flag tells the upstream logic to hold back writes.

Top module: `coded_row_tracker`

## Requirements
- R1: Row codes are 2'b00 (data and parity agree), 2'b01 (data newer, parity to be recomputed) and 2'b10 (a parity bank newer, data and parity to be rebuilt). After reset every row reads 2'b00, `rc_valid` is 0 and `q_full` is 0. `rd_code` follows `rd_bank`/`rd_row` with no clock delay.
- R2: An accepted write to a data bank (`wr_to_par`=0) sets that row to 2'b01. It queues a job with `rc_dir`=0 whose stale mask holds exactly the parity banks built from that data bank. Mask bit `b` stands for data bank `b`, and bit `NUM_BANKS+p` stands for parity bank `p`.
- R3: A write redirected to parity bank `wr_par` for data bank `wr_bank` lands in the same row of that parity bank. It sets the row to 2'b10 and queues a job with `rc_dir`=1. The job's mask holds the data bank plus every other parity bank built from that data bank.
- R4: A parity write whose parity bank is not built from `wr_bank` (the parity index is neither `wr_bank` nor `wr_bank-1`) is refused. It leaves the row code unchanged and queues nothing.
- R5: Each job carries the cycle count of its write. The counter is 0 in the first cycle after reset and rises by one every cycle. The head presented on `rc_*` is the pending job with the oldest stamp.
- R6: A write to a row that already has a pending job replaces that job's stale mask and direction. It keeps the job's original stamp and adds no second entry.
- R7: `q_full` is 1 exactly when `QDEPTH` jobs are pending. While the queue is full, a write to a row with no pending job is refused and leaves its code unchanged. A write to a row that is already pending is still accepted.
- R8: `rc_done` while `rc_valid` removes the head job and returns its row to 2'b00. If a write to the head's own row is accepted in the same cycle, the write wins: the row takes the write's code and the job stays pending with the new mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | A served write is reported this cycle |
| wr_bank | input | BANK_W | Data bank the write was meant for |
| wr_row | input | ROW_W | Row of the write (same row in data and parity) |
| wr_to_par | input | 1 | 1 if the write landed in a parity bank |
| wr_par | input | PAR_W | Parity bank that took the write |
| rd_bank | input | BANK_W | Lookup bank |
| rd_row | input | ROW_W | Lookup row |
| rd_code | output | 2 | Freshness code of the looked-up row |
| rc_valid | output | 1 | A recode job is pending |
| rc_bank | output | BANK_W | Head job bank |
| rc_row | output | ROW_W | Head job row |
| rc_dir | output | 1 | 0: recompute parity, 1: rebuild data and parity |
| rc_stale | output | STALE_W | Head job stale-bank mask |
| rc_stamp | output | CNT_W | Head job cycle stamp |
| rc_done | input | 1 | Recode engine finished the head job |
| q_full | output | 1 | All queue slots are occupied |

## Verification
The bench writes, checks and completes every bank and row in turn with data writes. This separates a correct stale mask for edge banks, which have only one parity bank, from the mask for inner banks, which have two. It then tries every pairing of data bank and parity bank for redirected writes, which separates legal redirects from refused ones. A burst that fills the queue shows the difference between refusing a new row and accepting a rewrite of a pending row. Draining that burst exposes the pop order and whether stamps are kept. A write to the head row in the same cycle as its completion decides whether the write or the completion wins.

// File: rtl/crt_pkg.sv
package crt_pkg;
  typedef enum logic [1:0] {
    ROW_CLEAN    = 2'b00,
    ROW_DATA_NEW = 2'b01,
    ROW_PAR_NEW  = 2'b10
  } row_code_e;
endpackage

// File: rtl/crt_stale_gen.sv
module crt_stale_gen #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int PAR_W     = 2,
  parameter int STALE_W   = 7
) (
  input  logic [BANK_W-1:0]  bank,
  input  logic               to_par,
  input  logic [PAR_W-1:0]   par,
  output logic [STALE_W-1:0] mask,
  output logic               legal
);
  localparam int NPAR = NUM_BANKS - 1;

  logic [NPAR-1:0] covers;

  // parity p is built from data banks p and p+1
  for (genvar p = 0; p < NPAR; p++) begin : g_cov
    assign covers[p] = (int'(bank) == p) || (int'(bank) == p + 1);
  end

  always_comb begin
    mask  = '0;
    legal = 1'b1;
    if (!to_par) begin
      mask[STALE_W-1:NUM_BANKS] = covers;
    end else begin
      legal = (int'(par) < NPAR) && covers[par];
      mask[bank] = 1'b1;
      for (int p = 0; p < NPAR; p++)
        if (covers[p] && (p != int'(par))) mask[NUM_BANKS+p] = 1'b1;
    end
  end
endmodule

// File: rtl/crt_status_table.sv
module crt_status_table #(
  parameter int NUM_BANKS = 4,
  parameter int ROWS      = 8,
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_en,
  input  logic [BANK_W-1:0] clr_bank,
  input  logic [ROW_W-1:0]  clr_row,
  input  logic              set_en,
  input  logic [BANK_W-1:0] set_bank,
  input  logic [ROW_W-1:0]  set_row,
  input  logic [1:0]        set_code,
  input  logic [BANK_W-1:0] look_bank,
  input  logic [ROW_W-1:0]  look_row,
  output logic [1:0]        look_code
);
  localparam int ENTRIES = NUM_BANKS * ROWS;

  logic [1:0] st [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) st[i] <= crt_pkg::ROW_CLEAN;
    end else begin
      if (clr_en) st[int'(clr_bank) * ROWS + int'(clr_row)] <= crt_pkg::ROW_CLEAN;
      if (set_en) st[int'(set_bank) * ROWS + int'(set_row)] <= set_code;
    end
  end

  assign look_code = st[int'(look_bank) * ROWS + int'(look_row)];
endmodule

// File: rtl/crt_recode_queue.sv
module crt_recode_queue #(
  parameter int QDEPTH  = 4,
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 3,
  parameter int STALE_W = 7,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CNT_W-1:0]   now,
  input  logic               ins_en,
  input  logic [BANK_W-1:0]  ins_bank,
  input  logic [ROW_W-1:0]   ins_row,
  input  logic               ins_dir,
  input  logic [STALE_W-1:0] ins_stale,
  input  logic               pop_en,
  output logic               hit,
  output logic               full,
  output logic               head_valid,
  output logic [BANK_W-1:0]  head_bank,
  output logic [ROW_W-1:0]   head_row,
  output logic               head_dir,
  output logic [STALE_W-1:0] head_stale,
  output logic [CNT_W-1:0]   head_stamp
);
  localparam int QW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;

  logic [QDEPTH-1:0]  v;
  logic [BANK_W-1:0]  e_bank  [QDEPTH];
  logic [ROW_W-1:0]   e_row   [QDEPTH];
  logic               e_dir   [QDEPTH];
  logic [STALE_W-1:0] e_stale [QDEPTH];
  logic [CNT_W-1:0]   e_stamp [QDEPTH];

  logic [QW-1:0]    hit_idx, free_idx, head_idx;
  logic             free_found;
  logic [CNT_W-1:0] best_age;

  always_comb begin
    hit = 1'b0; hit_idx = '0;
    free_found = 1'b0; free_idx = '0;
    head_valid = 1'b0; head_idx = '0; best_age = '0;
    for (int i = 0; i < QDEPTH; i++) begin
      if (v[i] && e_bank[i] == ins_bank && e_row[i] == ins_row) begin
        hit = 1'b1; hit_idx = QW'(i);
      end
      if (!v[i] && !free_found) begin
        free_found = 1'b1; free_idx = QW'(i);
      end
      if (v[i] && (!head_valid || (now - e_stamp[i]) > best_age)) begin
        head_valid = 1'b1; head_idx = QW'(i); best_age = now - e_stamp[i];
      end
    end
  end

  assign full       = &v;
  assign head_bank  = e_bank[head_idx];
  assign head_row   = e_row[head_idx];
  assign head_dir   = e_dir[head_idx];
  assign head_stale = e_stale[head_idx];
  assign head_stamp = e_stamp[head_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      v <= '0;
    end else begin
      if (pop_en && head_valid && !(ins_en && hit && hit_idx == head_idx))
        v[head_idx] <= 1'b0;
      if (ins_en && hit) begin
        e_dir[hit_idx]   <= ins_dir;
        e_stale[hit_idx] <= ins_stale;
      end else if (ins_en && free_found) begin
        v[free_idx]       <= 1'b1;
        e_bank[free_idx]  <= ins_bank;
        e_row[free_idx]   <= ins_row;
        e_dir[free_idx]   <= ins_dir;
        e_stale[free_idx] <= ins_stale;
        e_stamp[free_idx] <= now;
      end
    end
  end
endmodule

// File: rtl/coded_row_tracker.sv
module coded_row_tracker #(
  parameter int NUM_BANKS = 4,
  parameter int ROWS      = 8,
  parameter int QDEPTH    = 4,
  parameter int CNT_W     = 16,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ROW_W    = $clog2(ROWS),
  localparam int NPAR     = NUM_BANKS - 1,
  localparam int PAR_W    = (NPAR > 1) ? $clog2(NPAR) : 1,
  localparam int STALE_W  = NUM_BANKS + NPAR
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_valid,
  input  logic [BANK_W-1:0]  wr_bank,
  input  logic [ROW_W-1:0]   wr_row,
  input  logic               wr_to_par,
  input  logic [PAR_W-1:0]   wr_par,
  input  logic [BANK_W-1:0]  rd_bank,
  input  logic [ROW_W-1:0]   rd_row,
  output logic [1:0]         rd_code,
  output logic               rc_valid,
  output logic [BANK_W-1:0]  rc_bank,
  output logic [ROW_W-1:0]   rc_row,
  output logic               rc_dir,
  output logic [STALE_W-1:0] rc_stale,
  output logic [CNT_W-1:0]   rc_stamp,
  input  logic               rc_done,
  output logic               q_full
);
  logic [CNT_W-1:0]   cycle_cnt;
  logic [STALE_W-1:0] new_mask;
  logic               legal, hit, accept;

  always_ff @(posedge clk) begin
    if (rst) cycle_cnt <= '0;
    else     cycle_cnt <= cycle_cnt + 1'b1;
  end

  crt_stale_gen #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .PAR_W(PAR_W), .STALE_W(STALE_W)
  ) u_mask (
    .bank(wr_bank), .to_par(wr_to_par), .par(wr_par),
    .mask(new_mask), .legal(legal)
  );

  assign accept = wr_valid && legal && (!q_full || hit);

  crt_recode_queue #(
    .QDEPTH(QDEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W),
    .STALE_W(STALE_W), .CNT_W(CNT_W)
  ) u_queue (
    .clk(clk), .rst(rst), .now(cycle_cnt),
    .ins_en(accept), .ins_bank(wr_bank), .ins_row(wr_row),
    .ins_dir(wr_to_par), .ins_stale(new_mask),
    .pop_en(rc_done), .hit(hit), .full(q_full),
    .head_valid(rc_valid), .head_bank(rc_bank), .head_row(rc_row),
    .head_dir(rc_dir), .head_stale(rc_stale), .head_stamp(rc_stamp)
  );

  crt_status_table #(
    .NUM_BANKS(NUM_BANKS), .ROWS(ROWS), .BANK_W(BANK_W), .ROW_W(ROW_W)
  ) u_table (
    .clk(clk), .rst(rst),
    .clr_en(rc_done && rc_valid), .clr_bank(rc_bank), .clr_row(rc_row),
    .set_en(accept), .set_bank(wr_bank), .set_row(wr_row),
    .set_code(wr_to_par ? crt_pkg::ROW_PAR_NEW : crt_pkg::ROW_DATA_NEW),
    .look_bank(rd_bank), .look_row(rd_row), .look_code(rd_code)
  );
endmodule

// File: rtl/crt_checker.sv
module crt_checker #(
  parameter int NUM_BANKS = 4,
  parameter int ROWS      = 8,
  parameter int CNT_W     = 16,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ROW_W    = $clog2(ROWS),
  localparam int STALE_W  = NUM_BANKS + NUM_BANKS - 1
) (
  input logic               clk,
  input logic               rst,
  input logic [1:0]         rd_code,
  input logic               rc_valid,
  input logic [BANK_W-1:0]  rc_bank,
  input logic [ROW_W-1:0]   rc_row,
  input logic               rc_dir,
  input logic [STALE_W-1:0] rc_stale,
  input logic [CNT_W-1:0]   rc_stamp,
  input logic               rc_done,
  input logic               q_full
);
  // R1: the unused code never appears
  a_r1_code_legal: assert property (@(posedge clk) disable iff (rst)
    rd_code != 2'b11);

  // R2: a data-fresh job never marks a data bank stale
  a_r2_dir0_parity_only: assert property (@(posedge clk) disable iff (rst)
    (rc_valid && !rc_dir) |-> (rc_stale[NUM_BANKS-1:0] == '0));

  // R3: a parity-fresh job always marks its own data bank stale
  a_r3_dir1_own_bank: assert property (@(posedge clk) disable iff (rst)
    (rc_valid && rc_dir) |-> rc_stale[rc_bank]);

  // R5: the head stays put until it is completed
  a_r5_head_stable: assert property (@(posedge clk) disable iff (rst)
    (rc_valid && !rc_done) |=> (rc_valid && $stable(rc_bank) &&
                                $stable(rc_row) && $stable(rc_stamp)));

  // R7: a full queue always has a head; full drops only after a completion
  a_r7_full_has_head: assert property (@(posedge clk) disable iff (rst)
    q_full |-> rc_valid);
  a_r7_full_falls_on_done: assert property (@(posedge clk) disable iff (rst)
    $fell(q_full) |-> $past(rc_done));
endmodule

bind coded_row_tracker crt_checker #(
  .NUM_BANKS(NUM_BANKS), .ROWS(ROWS), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/sim_coded_row_tracker.sv
`timescale 1ns/1ps
module sim_coded_row_tracker;
  localparam int NB = 4, NR = 8, QD = 4, CW = 16;

  logic clk = 0, rst = 1;
  logic wr_valid = 0, wr_to_par = 0, rc_done = 0;
  logic [1:0] wr_bank = 0, wr_par = 0, rd_bank = 0, rc_bank;
  logic [2:0] wr_row = 0, rd_row = 0, rc_row;
  logic [1:0] rd_code;
  logic rc_valid, rc_dir, q_full;
  logic [6:0] rc_stale;
  logic [CW-1:0] rc_stamp;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  coded_row_tracker #(.NUM_BANKS(NB), .ROWS(NR), .QDEPTH(QD), .CNT_W(CW)) u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int covers(input int p, input int b);
    return (p == b || p + 1 == b) ? 1 : 0;
  endfunction

  function automatic int mask_data(input int b);
    int m = 0;
    for (int p = 0; p < NB - 1; p++) if (covers(p, b) != 0) m |= 1 << (NB + p);
    return m;
  endfunction

  function automatic int mask_par(input int b, input int p0);
    int m = 1 << b;
    for (int p = 0; p < NB - 1; p++)
      if (covers(p, b) != 0 && p != p0) m |= 1 << (NB + p);
    return m;
  endfunction

  task automatic look(input int b, input int r, output int code);
    rd_bank = 2'(b); rd_row = 3'(r); #1; code = int'(rd_code);
  endtask

  // drive at a falling edge, hold across one rising edge
  task automatic wr(input int b, input int r, input bit par, input int p);
    @(negedge clk);
    wr_valid = 1; wr_bank = 2'(b); wr_row = 3'(r); wr_to_par = par; wr_par = 2'(p);
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic done1();
    @(negedge clk); rc_done = 1;
    @(negedge clk); rc_done = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int c;
    int s0, s1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rc_valid", rc_valid, 0);
    chk("R1 q_full", q_full, 0);
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < NR; r++) begin look(b, r, c); chk("R1 reset code", c, 0); end

    // R2 / R8 data-write sweep over every bank and row
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < NR; r++) begin
        wr(b, r, 0, 0);
        look(b, r, c); chk("R2 code", c, 1);
        chk("R2 rc_valid", rc_valid, 1);
        chk("R2 bank/row", {rc_bank, rc_row}, (b << 3) | r);
        chk("R2 dir", rc_dir, 0);
        chk("R2 stale", rc_stale, mask_data(b));
        done1();
        look(b, r, c); chk("R8 cleared", c, 0);
        chk("R8 empty", rc_valid, 0);
      end

    // R3 / R4 parity-write sweep over every bank and parity index
    for (int b = 0; b < NB; b++)
      for (int p = 0; p < 4; p++) begin
        wr(b, 5, 1, p);
        look(b, 5, c);
        if (p < NB - 1 && covers(p, b) != 0) begin
          chk("R3 code", c, 2);
          chk("R3 dir", rc_dir, 1);
          chk("R3 stale", rc_stale, mask_par(b, p));
          done1();
        end else begin
          chk("R4 refused code", c, 0);
          chk("R4 refused queue", rc_valid, 0);
        end
      end

    // R5 / R7 fill the queue back to back
    @(negedge clk);
    for (int k = 0; k < QD; k++) begin
      wr_valid = 1; wr_bank = 2'(k); wr_row = 3'(k + 1); wr_to_par = 0;
      @(negedge clk);
    end
    wr_valid = 0;
    chk("R7 full", q_full, 1);
    chk("R5 oldest head", {rc_bank, rc_row}, (0 << 3) | 1);
    s0 = int'(rc_stamp);
    wr(1, 5, 0, 0);
    look(1, 5, c); chk("R7 refused while full", c, 0);
    chk("R7 still full", q_full, 1);
    // R6 rewrite of pending row (1,2) via parity 1
    wr(1, 2, 1, 1);
    look(1, 2, c); chk("R6 rewrite accepted", c, 2);
    done1();
    chk("R7 full dropped", q_full, 0);
    chk("R5 second head", {rc_bank, rc_row}, (1 << 3) | 2);
    chk("R6 dir replaced", rc_dir, 1);
    chk("R6 stale replaced", rc_stale, mask_par(1, 1));
    s1 = int'(rc_stamp);
    chk("R6 stamp kept (R5 step of one)", (s1 - s0) & 16'hffff, 1);
    done1();
    chk("R5 third head", {rc_bank, rc_row}, (2 << 3) | 3);
    done1();
    chk("R5 fourth head", {rc_bank, rc_row}, (3 << 3) | 4);
    done1();
    chk("R6 no duplicate left", rc_valid, 0);

    // R8 write to head row in the completion cycle
    wr(2, 6, 0, 0);
    @(negedge clk);
    rc_done = 1; wr_valid = 1; wr_bank = 2; wr_row = 6; wr_to_par = 1; wr_par = 2;
    @(negedge clk);
    rc_done = 0; wr_valid = 0;
    look(2, 6, c); chk("R8 write wins code", c, 2);
    chk("R8 job kept", rc_valid, 1);
    chk("R8 new stale", rc_stale, mask_par(2, 2));
    done1();
    look(2, 6, c); chk("R8 final clean", c, 0);
    chk("R8 final empty", rc_valid, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule